// File: doc/BRIEF.md
# PHY control register bank

A bank of 32-bit control and status registers that configures a USB PHY. A host reaches it over a simple word-wide bus. The bus has separate write and read strobes, a byte address inside a 4 KiB window and 32-bit data. Only aligned whole-word accesses are used, so the two low address bits are ignored. The word index is the byte address divided by four.

Each of the six writable main registers that take aliases has three companion words directly above it. A write to the first companion ORs the data in (set), a write to the second clears the bits given in the data (clear), and a write to the third XORs the data in (toggle). A read of any companion returns the main register. The registers are power-down, transmit, receive, control, debug and debug1. Bit 31 of control requests a soft reset. The soft reset is a one-cycle internal pulse that reloads power-down, transmit, receive and control and leaves the other registers alone. The active-low synchronous reset loads every register. The register contents are driven out continuously to the PHY.

Reads go through a two-state response machine. RD_IDLE moves to RD_RESP on a read strobe and then returns to RD_IDLE. RD_RESP also stays in RD_RESP on a back-to-back strobe. In RD_RESP the captured word is presented with a valid flag.

Top module: `phy_ctrl_regbank`

## Requirements
- R1: Word map: power-down 0x00, transmit 0x04, receive 0x08, control 0x0C, debug 0x14 and debug1 0x1C. Each of these has set/clear/toggle companions at +1/+2/+3. Status sits at 0x10 with direct access only. A read-only zero word sits at 0x18 and a read-only version word reading 0x04020000 sits at 0x20.
- R2: A direct write to a main register or to status replaces its value on the next clock edge.
- R3: A write to the +1 companion ORs the data into the main register. A write to +2 clears the bits that are 1 in the data. A write to +3 XORs the data into the main register.
- R4: A read of any companion word returns the current value of its main register.
- R5: A read strobe at one edge presents the data with rd_valid high for exactly the following cycle. rd_valid is low in cycles that no strobe precedes.
- R6: After the synchronous reset the values are: power-down 0x001E1C00, transmit 0x10060607, receive 0, control 0xC0200000, status 0, debug 0x7F180000, debug1 0x00001000.
- R7: A direct or set write to control with data bit 31 = 1 leaves power-down, transmit, receive and control at their R6 values on the next cycle.
- R8: A toggle write to control with data bit 31 = 1 causes a soft reset only when control bit 31 was 0 before the write, that is, when it is 1 after the toggle. Otherwise control just takes the XOR.
- R9: A clear write to control never causes a soft reset. Neither does any write to control whose data bit 31 is 0.
- R10: A soft reset leaves status, debug and debug1 unchanged.
- R11: Writes to 0x18, 0x20 and unmapped words change nothing. Reads of unmapped words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous full reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (12) | Byte address inside the window |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response flag |
| phy_pwd | output | DATA_W (32) | Power-down register |
| phy_tx | output | DATA_W (32) | Transmit register |
| phy_rx | output | DATA_W (32) | Receive register |
| phy_ctrl | output | DATA_W (32) | Control register |
| phy_dbg | output | DATA_W (32) | Debug register |
| phy_dbg1 | output | DATA_W (32) | Debug1 register |

## Verification
The bench targets the soft-reset trigger rules. A toggle of control that drops bit 31 must not reload power-down. A second toggle that raises bit 31 must reload it. A clear of bit 31 must never reload it. A design that tests only the data bit would reload on the first toggle and on the clear, and the bench would see power-down snap back to its default. The bench also checks that a soft reset spares status and both debug registers, which a design reusing the full reset path would wipe. It checks that companion reads return the main value and do not read as unmapped zeros. Finally, writes to the read-only and unmapped words are read back to show they have no effect.

// File: rtl/phy_rb_pkg.sv
package phy_rb_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } alias_op_e;

    localparam int NUM_RW     = 7;
    localparam int IDX_PWD    = 0;
    localparam int IDX_TX     = 1;
    localparam int IDX_RX     = 2;
    localparam int IDX_CTRL   = 3;
    localparam int IDX_STATUS = 4;
    localparam int IDX_DBG    = 5;
    localparam int IDX_DBG1   = 6;

    localparam int WORD_CTRL    = 'h0C;
    localparam int WORD_DBG0ST  = 'h18;
    localparam int WORD_VERSION = 'h20;
    localparam int SOFT_BIT     = 31;

    localparam logic [31:0] VERSION_VAL = 32'h0402_0000;
    localparam logic [31:0] PWD_INIT    = 32'h001E_1C00;
    localparam logic [31:0] TX_INIT     = 32'h1006_0607;
    localparam logic [31:0] RX_INIT     = 32'h0000_0000;
    localparam logic [31:0] CTRL_INIT   = 32'hC020_0000;
    localparam logic [31:0] STATUS_INIT = 32'h0000_0000;
    localparam logic [31:0] DBG_INIT    = 32'h7F18_0000;
    localparam logic [31:0] DBG1_INIT   = 32'h0000_1000;

    function automatic int reg_base(int idx);
        case (idx)
            IDX_PWD:    return 'h00;
            IDX_TX:     return 'h04;
            IDX_RX:     return 'h08;
            IDX_CTRL:   return 'h0C;
            IDX_STATUS: return 'h10;
            IDX_DBG:    return 'h14;
            default:    return 'h1C;
        endcase
    endfunction

    function automatic bit reg_aliased(int idx);
        return idx != IDX_STATUS;
    endfunction

    function automatic bit reg_in_soft(int idx);
        return idx <= IDX_CTRL;
    endfunction

    function automatic logic [31:0] reg_init(int idx);
        case (idx)
            IDX_PWD:    return PWD_INIT;
            IDX_TX:     return TX_INIT;
            IDX_RX:     return RX_INIT;
            IDX_CTRL:   return CTRL_INIT;
            IDX_STATUS: return STATUS_INIT;
            IDX_DBG:    return DBG_INIT;
            default:    return DBG1_INIT;
        endcase
    endfunction

endpackage

// File: rtl/phy_rb_word.sv
module phy_rb_word
    import phy_rb_pkg::*;
#(
    parameter int          WORD_W  = 10,
    parameter int          DATA_W  = 32,
    parameter int          BASE    = 0,
    parameter bit          ALIASED = 1'b1,
    parameter logic [31:0] INIT    = 32'h0,
    parameter bit          IN_SOFT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              soft_rst,
    output logic [DATA_W-1:0] q,
    output logic              hit
);
    localparam logic [WORD_W-1:0] BASE_W = WORD_W'(BASE);
    localparam logic [DATA_W-1:0] INIT_W = DATA_W'(INIT);

    alias_op_e         op;
    logic [DATA_W-1:0] q_next;

    generate
        if (ALIASED) begin : g_alias
            assign hit = (word_addr[WORD_W-1:2] == BASE_W[WORD_W-1:2]);
            assign op  = alias_op_e'(word_addr[1:0]);
        end else begin : g_plain
            assign hit = (word_addr == BASE_W);
            assign op  = OP_WRITE;
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_WRITE: q_next = wdata;
            OP_SET:   q_next = q | wdata;
            OP_CLR:   q_next = q & ~wdata;
            OP_TOG:   q_next = q ^ wdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT_W;
        end else if (IN_SOFT && soft_rst) begin
            q <= INIT_W;
        end else if (wr_en && hit) begin
            q <= q_next;
        end
    end
endmodule

// File: rtl/phy_rb_softrst.sv
module phy_rb_softrst
    import phy_rb_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word_addr,
    input  logic              wdata_msb,
    input  logic              ctrl_msb,
    output logic              soft_pulse
);
    localparam logic [WORD_W-1:0] CTRL_W = WORD_W'(WORD_CTRL);

    logic      ctrl_hit;
    alias_op_e op;
    logic      fire;

    assign ctrl_hit = wr_en && (word_addr[WORD_W-1:2] == CTRL_W[WORD_W-1:2]);
    assign op       = alias_op_e'(word_addr[1:0]);

    always_comb begin
        unique case (op)
            OP_WRITE: fire = wdata_msb;
            OP_SET:   fire = wdata_msb;
            OP_CLR:   fire = 1'b0;
            OP_TOG:   fire = wdata_msb && !ctrl_msb;
        endcase
    end

    assign soft_pulse = ctrl_hit && fire;
endmodule

// File: rtl/phy_rb_rdresp.sv
module phy_rb_rdresp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef enum logic {RD_IDLE, RD_RESP} rd_state_e;

    rd_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = rd_en ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_en ? RD_RESP : RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_word;
    end

    assign rd_valid = (state_q == RD_RESP);
endmodule

// File: rtl/phy_ctrl_regbank.sv
module phy_ctrl_regbank
    import phy_rb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] phy_pwd,
    output logic [DATA_W-1:0] phy_tx,
    output logic [DATA_W-1:0] phy_rx,
    output logic [DATA_W-1:0] phy_ctrl,
    output logic [DATA_W-1:0] phy_dbg,
    output logic [DATA_W-1:0] phy_dbg1
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] DBG0_W = WORD_W'(WORD_DBG0ST);
    localparam logic [WORD_W-1:0] VER_W  = WORD_W'(WORD_VERSION);
    localparam logic [DATA_W-1:0] VER_D  = DATA_W'(VERSION_VAL);

    logic [WORD_W-1:0] word_addr;
    logic [DATA_W-1:0] reg_q [NUM_RW];
    logic [NUM_RW-1:0] reg_hit;
    logic              soft_pulse;
    logic [DATA_W-1:0] rd_word;

    assign word_addr = bus_addr[ADDR_W-1:2];

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
            phy_rb_word #(
                .WORD_W (WORD_W),
                .DATA_W (DATA_W),
                .BASE   (reg_base(g)),
                .ALIASED(reg_aliased(g)),
                .INIT   (reg_init(g)),
                .IN_SOFT(reg_in_soft(g))
            ) u_word (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en),
                .word_addr(word_addr),
                .wdata    (wr_data),
                .soft_rst (soft_pulse),
                .q        (reg_q[g]),
                .hit      (reg_hit[g])
            );
        end
    endgenerate

    phy_rb_softrst #(.WORD_W(WORD_W)) u_softrst (
        .wr_en     (wr_en),
        .word_addr (word_addr),
        .wdata_msb (wr_data[SOFT_BIT]),
        .ctrl_msb  (reg_q[IDX_CTRL][SOFT_BIT]),
        .soft_pulse(soft_pulse)
    );

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (reg_hit[i]) rd_word = reg_q[i];
        end
        if (word_addr == DBG0_W) rd_word = '0;
        if (word_addr == VER_W)  rd_word = VER_D;
    end

    phy_rb_rdresp #(.DATA_W(DATA_W)) u_rdresp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_word (rd_word),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    assign phy_pwd  = reg_q[IDX_PWD];
    assign phy_tx   = reg_q[IDX_TX];
    assign phy_rx   = reg_q[IDX_RX];
    assign phy_ctrl = reg_q[IDX_CTRL];
    assign phy_dbg  = reg_q[IDX_DBG];
    assign phy_dbg1 = reg_q[IDX_DBG1];
endmodule

// File: rtl/phy_rb_checker.sv
module phy_rb_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] phy_pwd,
    input logic [DATA_W-1:0] phy_ctrl,
    input logic [DATA_W-1:0] phy_dbg,
    input logic              soft_pulse
);
    localparam int WORD_W = ADDR_W - 2;
    logic [WORD_W-1:0] w;
    assign w = bus_addr[ADDR_W-1:2];

    p_rd_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_rd_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w == WORD_W'(1)) |=> phy_pwd == ($past(phy_pwd) | $past(wr_data)));
    p_soft_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_pulse |=> (phy_pwd == DATA_W'(32'h001E_1C00)) && (phy_ctrl == DATA_W'(32'hC020_0000)));
    p_clr_no_soft_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w == WORD_W'(14)) |-> !soft_pulse);
    p_dbg_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_pulse |=> $stable(phy_dbg));
    p_version_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && w == WORD_W'(32)) |=> rd_data == DATA_W'(32'h0402_0000));
    p_ro_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w == WORD_W'(24)) |=> $stable(phy_pwd) && $stable(phy_ctrl) && $stable(phy_dbg));
endmodule

bind phy_ctrl_regbank phy_rb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .bus_addr  (bus_addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .phy_pwd   (phy_pwd),
    .phy_ctrl  (phy_ctrl),
    .phy_dbg   (phy_dbg),
    .soft_pulse(soft_pulse)
);

// File: tb/test_phy_ctrl_regbank.sv
module test_phy_ctrl_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, phy_pwd, phy_tx, phy_rx, phy_ctrl, phy_dbg, phy_dbg1;
    logic        rd_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    phy_ctrl_regbank i_phy_ctrl_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .phy_pwd(phy_pwd), .phy_tx(phy_tx),
        .phy_rx(phy_rx), .phy_ctrl(phy_ctrl), .phy_dbg(phy_dbg),
        .phy_dbg1(phy_dbg1)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(int word, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; bus_addr = 12'(word * 4); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int word, logic [31:0] e, string tag);
        @(negedge clk);
        rd_en = 1'b1; bus_addr = 12'(word * 4);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: pops expected read data as responses appear (R5)
    always @(negedge clk) begin
        if (rst_n && !done && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R5 unexpected rd_valid: actual=1 expected=0");
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset values
        chk("R6 pwd",  phy_pwd,  32'h001E1C00);
        chk("R6 tx",   phy_tx,   32'h10060607);
        chk("R6 rx",   phy_rx,   32'h0);
        chk("R6 ctrl", phy_ctrl, 32'hC0200000);
        chk("R6 dbg",  phy_dbg,  32'h7F180000);
        chk("R6 dbg1", phy_dbg1, 32'h00001000);
        chk("R5 idle valid", 32'(rd_valid), 32'h0);
        rd('h10, 32'h0, "R6 status read");
        rd('h18, 32'h0, "R1 dbg0 status read");
        rd('h20, 32'h04020000, "R1 version read");
        rd('h0C, 32'hC0200000, "R1 ctrl read");
        @(negedge clk);
        chk("R5 valid drops", 32'(rd_valid), 32'h0);

        // R2 direct writes
        wr('h00, 32'h12345678);
        chk("R2 pwd direct", phy_pwd, 32'h12345678);
        wr('h10, 32'h00000055);
        rd('h10, 32'h00000055, "R2 status direct");
        wr('h0C, 32'h00000005);
        chk("R9 ctrl bit31 clear no soft ctrl", phy_ctrl, 32'h00000005);
        chk("R9 ctrl bit31 clear no soft pwd", phy_pwd, 32'h12345678);

        // R3 alias operations on transmit
        wr('h04, 32'h0000F0F0);
        wr('h05, 32'h0F000000);
        chk("R3 set", phy_tx, 32'h0F00F0F0);
        wr('h06, 32'h000000F0);
        chk("R3 clr", phy_tx, 32'h0F00F000);
        wr('h07, 32'hFF000001);
        chk("R3 tog", phy_tx, 32'hF000F001);
        // R4 alias reads
        rd('h05, 32'hF000F001, "R4 tx set alias read");
        rd('h06, 32'hF000F001, "R4 tx clr alias read");
        rd('h07, 32'hF000F001, "R4 tx tog alias read");
        // debug / debug1 aliases
        wr('h14, 32'hAAAA0000);
        wr('h1D, 32'h00000003);
        chk("R3 dbg1 set", phy_dbg1, 32'h00001003);
        wr('h1E, 32'h00001000);
        chk("R3 dbg1 clr", phy_dbg1, 32'h00000003);
        rd('h17, 32'hAAAA0000, "R4 dbg tog alias read");
        wr('h09, 32'h0000000F);
        chk("R3 rx set", phy_rx, 32'h0000000F);

        // R7 soft reset via set alias
        wr('h0D, 32'h80000000);
        chk("R7 set pwd", phy_pwd, 32'h001E1C00);
        chk("R7 set tx", phy_tx, 32'h10060607);
        chk("R7 set rx", phy_rx, 32'h0);
        chk("R7 set ctrl", phy_ctrl, 32'hC0200000);
        chk("R10 dbg kept", phy_dbg, 32'hAAAA0000);
        chk("R10 dbg1 kept", phy_dbg1, 32'h00000003);
        rd('h10, 32'h00000055, "R10 status kept");

        // R7 soft reset via direct write
        wr('h00, 32'h11110000);
        wr('h0C, 32'h80000001);
        chk("R7 direct ctrl", phy_ctrl, 32'hC0200000);
        chk("R7 direct pwd", phy_pwd, 32'h001E1C00);

        // R8 toggle rule: bit31 1 -> 0, no soft reset
        wr('h00, 32'h22220000);
        wr('h0F, 32'h80000000);
        chk("R8 tog to zero ctrl", phy_ctrl, 32'h40200000);
        chk("R8 tog to zero pwd kept", phy_pwd, 32'h22220000);
        // toggle 0 -> 1 fires
        wr('h0F, 32'h80000000);
        chk("R8 tog to one ctrl", phy_ctrl, 32'hC0200000);
        chk("R8 tog to one pwd", phy_pwd, 32'h001E1C00);

        // R9 clear never fires
        wr('h00, 32'h33330000);
        wr('h0E, 32'h80000000);
        chk("R9 clr ctrl", phy_ctrl, 32'h40200000);
        chk("R9 clr pwd kept", phy_pwd, 32'h33330000);

        // R11 ignored writes and unmapped reads
        wr('h18, 32'hFFFFFFFF);
        wr('h20, 32'hFFFFFFFF);
        wr('h11, 32'hFFFFFFFF);
        wr('h100, 32'hFFFFFFFF);
        chk("R11 pwd untouched", phy_pwd, 32'h33330000);
        chk("R11 dbg untouched", phy_dbg, 32'hAAAA0000);
        rd('h18, 32'h0, "R11 dbg0 status after write");
        rd('h20, 32'h04020000, "R11 version after write");
        rd('h11, 32'h0, "R11 unmapped read 0x11");
        rd('h100, 32'h0, "R11 unmapped read 0x100");
        rd('h10, 32'h00000055, "R11 status untouched");

        repeat (2) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL R5 missing responses: actual=%0d expected=0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule